// File: doc/BRIEF.md
# Outstanding Miss Queue with Ordered Downstream Issue

This block sits between a data cache's request dispatcher and the next memory level. It keeps every request that needs a downstream access in one of two queues. The read-side queue takes cached read misses, cached write misses and uncached reads. The write-side queue takes uncached writes and writebacks of dirty lines. Each accepted request is stamped with an order number from a wrapping counter. Cached requests that hit a line already waiting in the read-side queue are folded into that entry. One downstream access then answers all of them.

An arbiter chooses which queue head goes downstream next. It prefers the read side, hands the slot to the write side when that queue is full, and never lets an access overtake an older access to the same line waiting in the other queue. Only one downstream access is in flight at a time. When its response arrives, the block reports every order number that the entry served, all in the same cycle. The dispatcher uses the full flags and the per-line threshold flag to hold back requests that cannot be taken.

Top module: `miss_issue_queue`

## Requirements
- R1: Each accepted request (req_valid and req_ready both high at a rising edge) is given the value shown on req_ord in that cycle. The counter starts at 0 after reset, rises by one per accepted request and wraps modulo 2^ORD_W.
- R2: A cached read (kind 0) or cached write (kind 1) whose line matches an unissued cached entry in the read-side queue joins that entry. The entry needs one downstream access, and its response reports all joined order numbers at once, oldest in slot 0 of cpl_ords.
- R3: A joined entry keeps the order number of the request that created it, and the first completion slot carries that number.
- R4: An uncached read (kind 2) always takes its own entry and is never joined with another request, even for the same line.
- R5: Within each queue, entries go downstream strictly in order-number order.
- R6: When both queue heads are eligible, the read-side head goes first unless the write-side queue is full, in which case the write-side head goes first.
- R7: A queue head is not issued while the other queue holds an older entry (by serial-number comparison of order numbers) for the same line. This holds across wrap-around of the counter.
- R8: dn_op is 0 for a shared read, 1 for a read-side entry that contains at least one cached write, and 2 for a write-side entry. dn_size is LINE_BYTES for cached requests and writebacks, and req_size for uncached ones.
- R9: mq_full or wq_full is high when its queue holds its configured depth. A request bound for a full queue is refused (req_ready low) unless it joins an existing entry.
- R10: line_thr is high when req_line matches an unissued joinable entry that already holds THRESH requests. A cached request to that line is refused.
- R11: Kinds 3 (uncached write) and 4 (writeback) go to the write-side queue. Kinds 5 to 7 are refused, cause no downstream access and use no order number.
- R12: At most one downstream access is outstanding. A dn_rsp_valid pulse while an access is outstanding raises cpl_valid in that cycle, together with cpl_cnt and the order numbers, and frees the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | 0 cached read, 1 cached write, 2 uncached read, 3 uncached write, 4 writeback |
| req_line | input | LINE_W | Line address of the request |
| req_size | input | SIZE_W | Byte count for uncached requests |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ord | output | ORD_W | Order number given to a request accepted this cycle |
| mq_full | output | 1 | Read-side queue holds MQ_DEPTH entries |
| wq_full | output | 1 | Write-side queue holds WQ_DEPTH entries |
| line_thr | output | 1 | Joinable entry for req_line has THRESH requests |
| dn_valid | output | 1 | Downstream access offered |
| dn_ready | input | 1 | Downstream takes the offered access |
| dn_op | output | 2 | 0 read, 1 read exclusive, 2 write |
| dn_line | output | LINE_W | Line address of the access |
| dn_size | output | SIZE_W | Byte count of the access |
| dn_rsp_valid | input | 1 | Response for the outstanding access |
| cpl_valid | output | 1 | Completions reported this cycle |
| cpl_cnt | output | CNT_W | Number of valid completion slots |
| cpl_ords | output | THRESH*ORD_W | Order numbers, slot 0 in the low bits, oldest first |

## Verification
Three requests to one cached line, one of them a write, show whether joining happens. The result should be one exclusive access and three completions in one cycle. Two uncached reads to a single line tell a queue that joins everything apart from one that keeps uncached requests separate. An older uncached write followed by a newer cached read to a different line shows read preference. The same pair aimed at one line shows the overlap hold. Repeating that pair where the counter wraps from its top value to zero separates serial-number comparison from plain magnitude comparison. Filling each queue, and stacking THRESH requests on one line, drives the full and threshold refusals. Illegal kinds confirm that nothing is taken and no order number is used.

// File: rtl/mq_pkg.sv
package mq_pkg;

  // request kinds seen on req_kind
  localparam logic [2:0] KIND_CRD = 3'd0;
  localparam logic [2:0] KIND_CWR = 3'd1;
  localparam logic [2:0] KIND_URD = 3'd2;
  localparam logic [2:0] KIND_UWR = 3'd3;
  localparam logic [2:0] KIND_WB  = 3'd4;

  // downstream operation codes
  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_RDX = 2'd1;
  localparam logic [1:0] OP_WR  = 2'd2;

  // serial-number test: a is strictly older than b in a w-bit space
  function automatic logic ord_older(input logic [31:0] a, input logic [31:0] b,
                                     input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

endpackage

// File: rtl/ord_queue.sv
module ord_queue
  import mq_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int LINE_W   = 26,
  parameter int SIZE_W   = 7,
  parameter int ORD_W    = 6,
  parameter int THRESH   = 4,
  parameter bit MERGE    = 1'b1,
  parameter bit IS_WRITE = 1'b0,
  localparam int CNT_W   = $clog2(THRESH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_en,
  input  logic [LINE_W-1:0]       alloc_line,
  input  logic [SIZE_W-1:0]       alloc_size,
  input  logic                    alloc_excl,
  input  logic                    alloc_cached,
  input  logic [ORD_W-1:0]        alloc_ord,
  input  logic                    merge_en,
  input  logic                    merge_excl,
  input  logic [ORD_W-1:0]        merge_ord,
  output logic                    match,
  output logic                    match_full,
  output logic                    full,
  output logic                    head_valid,
  output logic [LINE_W-1:0]       head_line,
  output logic [SIZE_W-1:0]       head_size,
  output logic [1:0]              head_op,
  output logic [ORD_W-1:0]        head_ord,
  output logic [CNT_W-1:0]        head_cnt,
  output logic [THRESH*ORD_W-1:0] head_tgts,
  input  logic                    issue_en,
  input  logic                    pop_en,
  input  logic [LINE_W-1:0]       q_line,
  input  logic [ORD_W-1:0]        q_ord,
  output logic                    q_hit
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int TI_W  = (THRESH > 1) ? $clog2(THRESH) : 1;

  logic [DEPTH-1:0]  vld_q, vld_n, busy_q, busy_n, excl_q, excl_n, cach_q, cach_n;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [LINE_W-1:0] line_n [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [SIZE_W-1:0] size_n [DEPTH];
  logic [CNT_W-1:0]  cnt_q  [DEPTH];
  logic [CNT_W-1:0]  cnt_n  [DEPTH];
  logic [ORD_W-1:0]  tgt_q  [DEPTH][THRESH];
  logic [ORD_W-1:0]  tgt_n  [DEPTH][THRESH];
  logic [PTR_W-1:0]  hd_q, hd_n, tl_q, tl_n;
  logic [OCC_W-1:0]  occ_q, occ_n;

  logic              m_hit;
  logic [PTR_W-1:0]  m_idx;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // lookup of a joinable entry for the incoming line
  generate
    if (MERGE) begin : g_merge
      always_comb begin
        m_hit = 1'b0;
        m_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
          if (vld_q[i] && cach_q[i] && !busy_q[i] && (line_q[i] == alloc_line)) begin
            m_hit = 1'b1;
            m_idx = PTR_W'(i);
          end
        end
      end
    end else begin : g_nomerge
      assign m_hit = 1'b0;
      assign m_idx = '0;
    end
  endgenerate

  assign match      = m_hit;
  assign match_full = m_hit && (cnt_q[m_idx] == CNT_W'(THRESH));
  assign full       = (occ_q == OCC_W'(DEPTH));

  // head view
  assign head_valid = vld_q[hd_q];
  assign head_line  = line_q[hd_q];
  assign head_size  = size_q[hd_q];
  assign head_ord   = tgt_q[hd_q][0];
  assign head_cnt   = cnt_q[hd_q];
  assign head_op    = IS_WRITE ? OP_WR : (excl_q[hd_q] ? OP_RDX : OP_RD);

  always_comb begin
    for (int k = 0; k < THRESH; k++) begin
      head_tgts[k*ORD_W +: ORD_W] = tgt_q[hd_q][k];
    end
  end

  // older same-line entry search for the other queue's head
  always_comb begin
    q_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && (line_q[i] == q_line) &&
          ord_older(32'(tgt_q[i][0]), 32'(q_ord), ORD_W)) begin
        q_hit = 1'b1;
      end
    end
  end

  // next state
  always_comb begin
    vld_n  = vld_q;
    busy_n = busy_q;
    excl_n = excl_q;
    cach_n = cach_q;
    line_n = line_q;
    size_n = size_q;
    cnt_n  = cnt_q;
    tgt_n  = tgt_q;
    hd_n   = hd_q;
    tl_n   = tl_q;
    occ_n  = occ_q + OCC_W'(alloc_en) - OCC_W'(pop_en);

    if (issue_en) begin
      busy_n[hd_q] = 1'b1;
    end
    if (pop_en) begin
      vld_n[hd_q]  = 1'b0;
      busy_n[hd_q] = 1'b0;
      hd_n         = ptr_inc(hd_q);
    end
    if (merge_en && m_hit) begin
      tgt_n[m_idx][TI_W'(cnt_q[m_idx])] = merge_ord;
      cnt_n[m_idx]  = cnt_q[m_idx] + 1'b1;
      excl_n[m_idx] = excl_q[m_idx] | merge_excl;
    end
    if (alloc_en) begin
      vld_n[tl_q]    = 1'b1;
      busy_n[tl_q]   = 1'b0;
      excl_n[tl_q]   = alloc_excl;
      cach_n[tl_q]   = alloc_cached;
      line_n[tl_q]   = alloc_line;
      size_n[tl_q]   = alloc_size;
      cnt_n[tl_q]    = CNT_W'(1);
      tgt_n[tl_q][0] = alloc_ord;
      tl_n           = ptr_inc(tl_q);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      busy_q <= '0;
      excl_q <= '0;
      cach_q <= '0;
      hd_q   <= '0;
      tl_q   <= '0;
      occ_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i] <= '0;
        size_q[i] <= '0;
        cnt_q[i]  <= '0;
        for (int k = 0; k < THRESH; k++) begin
          tgt_q[i][k] <= '0;
        end
      end
    end else begin
      vld_q  <= vld_n;
      busy_q <= busy_n;
      excl_q <= excl_n;
      cach_q <= cach_n;
      hd_q   <= hd_n;
      tl_q   <= tl_n;
      occ_q  <= occ_n;
      line_q <= line_n;
      size_q <= size_n;
      cnt_q  <= cnt_n;
      tgt_q  <= tgt_n;
    end
  end

  // checks
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);  // R9

  AST_ORD_RISING: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && (occ_q != '0)) |-> ord_older(32'(head_ord), 32'(alloc_ord), ORD_W));  // R1

  AST_MERGE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |-> (m_hit && (cnt_q[m_idx] < CNT_W'(THRESH))));  // R10

  AST_POP_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (vld_q[hd_q] && busy_q[hd_q]));  // R12

  generate
    if (THRESH > 1) begin : g_cpl_chk
      AST_CPL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && (cnt_q[hd_q] >= CNT_W'(2))) |->
          ord_older(32'(tgt_q[hd_q][0]), 32'(tgt_q[hd_q][1]), ORD_W));  // R2
    end
  endgenerate

endmodule

// File: rtl/issue_arb.sv
module issue_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic mq_cand,
  input  logic mq_blk,
  input  logic wq_cand,
  input  logic wq_blk,
  input  logic wq_full,
  input  logic dn_ready,
  input  logic rsp_valid,
  output logic dn_valid,
  output logic pick_wq,
  output logic mq_issue,
  output logic wq_issue,
  output logic mq_pop,
  output logic wq_pop,
  output logic cpl_valid,
  output logic cpl_wq
);

  logic infl_q, infl_n, infl_wq_q, infl_wq_n;
  logic mq_ok, wq_ok, fire, done;

  assign mq_ok    = mq_cand && !mq_blk;
  assign wq_ok    = wq_cand && !wq_blk;
  assign pick_wq  = wq_ok && (!mq_ok || wq_full);
  assign dn_valid = !infl_q && (mq_ok || wq_ok);
  assign fire     = dn_valid && dn_ready;
  assign mq_issue = fire && !pick_wq;
  assign wq_issue = fire && pick_wq;

  assign done      = rsp_valid && infl_q;
  assign cpl_valid = done;
  assign cpl_wq    = infl_wq_q;
  assign mq_pop    = done && !infl_wq_q;
  assign wq_pop    = done && infl_wq_q;

  always_comb begin
    infl_n    = infl_q;
    infl_wq_n = infl_wq_q;
    if (done) begin
      infl_n = 1'b0;
    end
    if (fire) begin
      infl_n    = 1'b1;
      infl_wq_n = pick_wq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      infl_q    <= 1'b0;
      infl_wq_q <= 1'b0;
    end else begin
      infl_q    <= infl_n;
      infl_wq_q <= infl_wq_n;
    end
  end

  AST_PICK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (pick_wq ? wq_cand : mq_cand));  // R6

  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !dn_valid);  // R12

endmodule

// File: rtl/miss_issue_queue.sv
module miss_issue_queue
  import mq_pkg::*;
#(
  parameter int LINE_W     = 26,
  parameter int LINE_BYTES = 64,
  parameter int MQ_DEPTH   = 4,
  parameter int WQ_DEPTH   = 4,
  parameter int THRESH     = 4,
  parameter int ORD_W      = 6,
  localparam int SIZE_W    = $clog2(LINE_BYTES) + 1,
  localparam int CNT_W     = $clog2(THRESH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [2:0]              req_kind,
  input  logic [LINE_W-1:0]       req_line,
  input  logic [SIZE_W-1:0]       req_size,
  output logic                    req_ready,
  output logic [ORD_W-1:0]        req_ord,
  output logic                    mq_full,
  output logic                    wq_full,
  output logic                    line_thr,
  output logic                    dn_valid,
  input  logic                    dn_ready,
  output logic [1:0]              dn_op,
  output logic [LINE_W-1:0]       dn_line,
  output logic [SIZE_W-1:0]       dn_size,
  input  logic                    dn_rsp_valid,
  output logic                    cpl_valid,
  output logic [CNT_W-1:0]        cpl_cnt,
  output logic [THRESH*ORD_W-1:0] cpl_ords
);

  // request decode
  logic is_cached, to_mq, to_wq, accept, joins;
  logic [SIZE_W-1:0] alloc_size;
  logic [ORD_W-1:0]  ord_q, ord_n;

  // queue views
  logic mq_match, mq_match_full, mq_hv, mq_hit;
  logic wq_match, wq_match_full, wq_hv, wq_hit;
  logic [LINE_W-1:0] mq_hline, wq_hline;
  logic [SIZE_W-1:0] mq_hsize, wq_hsize;
  logic [1:0]        mq_hop, wq_hop;
  logic [ORD_W-1:0]  mq_hord, wq_hord;
  logic [CNT_W-1:0]  mq_hcnt, wq_hcnt;
  logic [THRESH*ORD_W-1:0] mq_htgts, wq_htgts;

  // arbiter wires
  logic pick_wq, mq_issue, wq_issue, mq_pop, wq_pop, cpl_wq;

  assign is_cached = (req_kind == KIND_CRD) || (req_kind == KIND_CWR);
  assign to_mq     = is_cached || (req_kind == KIND_URD);
  assign to_wq     = (req_kind == KIND_UWR) || (req_kind == KIND_WB);
  assign joins     = is_cached && mq_match;

  always_comb begin
    if (joins) begin
      req_ready = !mq_match_full;
    end else if (to_mq) begin
      req_ready = !mq_full;
    end else if (to_wq) begin
      req_ready = !wq_full && !(wq_match && wq_match_full);
    end else begin
      req_ready = 1'b0;
    end
  end

  assign accept     = req_valid && req_ready;
  assign req_ord    = ord_q;
  assign line_thr   = mq_match_full;
  assign alloc_size = (is_cached || (req_kind == KIND_WB)) ? SIZE_W'(LINE_BYTES) : req_size;

  // order counter, wraps naturally
  always_comb begin
    ord_n = ord_q;
    if (accept) begin
      ord_n = ord_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ord_q <= '0;
    end else begin
      ord_q <= ord_n;
    end
  end

  ord_queue #(
    .DEPTH   (MQ_DEPTH),
    .LINE_W  (LINE_W),
    .SIZE_W  (SIZE_W),
    .ORD_W   (ORD_W),
    .THRESH  (THRESH),
    .MERGE   (1'b1),
    .IS_WRITE(1'b0)
  ) u_mq (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (accept && to_mq && !joins),
    .alloc_line  (req_line),
    .alloc_size  (alloc_size),
    .alloc_excl  (req_kind == KIND_CWR),
    .alloc_cached(is_cached),
    .alloc_ord   (ord_q),
    .merge_en    (accept && joins),
    .merge_excl  (req_kind == KIND_CWR),
    .merge_ord   (ord_q),
    .match       (mq_match),
    .match_full  (mq_match_full),
    .full        (mq_full),
    .head_valid  (mq_hv),
    .head_line   (mq_hline),
    .head_size   (mq_hsize),
    .head_op     (mq_hop),
    .head_ord    (mq_hord),
    .head_cnt    (mq_hcnt),
    .head_tgts   (mq_htgts),
    .issue_en    (mq_issue),
    .pop_en      (mq_pop),
    .q_line      (wq_hline),
    .q_ord       (wq_hord),
    .q_hit       (mq_hit)
  );

  ord_queue #(
    .DEPTH   (WQ_DEPTH),
    .LINE_W  (LINE_W),
    .SIZE_W  (SIZE_W),
    .ORD_W   (ORD_W),
    .THRESH  (THRESH),
    .MERGE   (1'b0),
    .IS_WRITE(1'b1)
  ) u_wq (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (accept && to_wq),
    .alloc_line  (req_line),
    .alloc_size  (alloc_size),
    .alloc_excl  (1'b0),
    .alloc_cached(1'b0),
    .alloc_ord   (ord_q),
    .merge_en    (1'b0),
    .merge_excl  (1'b0),
    .merge_ord   (ord_q),
    .match       (wq_match),
    .match_full  (wq_match_full),
    .full        (wq_full),
    .head_valid  (wq_hv),
    .head_line   (wq_hline),
    .head_size   (wq_hsize),
    .head_op     (wq_hop),
    .head_ord    (wq_hord),
    .head_cnt    (wq_hcnt),
    .head_tgts   (wq_htgts),
    .issue_en    (wq_issue),
    .pop_en      (wq_pop),
    .q_line      (mq_hline),
    .q_ord       (mq_hord),
    .q_hit       (wq_hit)
  );

  issue_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .mq_cand  (mq_hv),
    .mq_blk   (wq_hit),
    .wq_cand  (wq_hv),
    .wq_blk   (mq_hit),
    .wq_full  (wq_full),
    .dn_ready (dn_ready),
    .rsp_valid(dn_rsp_valid),
    .dn_valid (dn_valid),
    .pick_wq  (pick_wq),
    .mq_issue (mq_issue),
    .wq_issue (wq_issue),
    .mq_pop   (mq_pop),
    .wq_pop   (wq_pop),
    .cpl_valid(cpl_valid),
    .cpl_wq   (cpl_wq)
  );

  // downstream and completion muxes
  assign dn_op    = pick_wq ? wq_hop   : mq_hop;
  assign dn_line  = pick_wq ? wq_hline : mq_hline;
  assign dn_size  = pick_wq ? wq_hsize : mq_hsize;
  assign cpl_cnt  = cpl_wq  ? wq_hcnt  : mq_hcnt;
  assign cpl_ords = cpl_wq  ? wq_htgts : mq_htgts;

  AST_WQ_NO_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_wq) |-> (cpl_cnt == CNT_W'(1)));  // R4

  AST_REFUSE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind > KIND_WB) |-> !req_ready);  // R11

endmodule

// File: tb/miss_issue_queue_tb.sv
module miss_issue_queue_tb;

  localparam int LW = 26;
  localparam int SW = 7;
  localparam int OW = 6;
  localparam int TH = 4;
  localparam int CW = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [2:0]        req_kind;
  logic [LW-1:0]     req_line;
  logic [SW-1:0]     req_size;
  logic              req_ready;
  logic [OW-1:0]     req_ord;
  logic              mq_full, wq_full, line_thr;
  logic              dn_valid, dn_ready;
  logic [1:0]        dn_op;
  logic [LW-1:0]     dn_line;
  logic [SW-1:0]     dn_size;
  logic              dn_rsp_valid;
  logic              cpl_valid;
  logic [CW-1:0]     cpl_cnt;
  logic [TH*OW-1:0]  cpl_ords;

  int n_chk = 0;
  int n_bad = 0;
  int ord_exp = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  miss_issue_queue u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_line(req_line), .req_size(req_size), .req_ready(req_ready), .req_ord(req_ord),
    .mq_full(mq_full), .wq_full(wq_full), .line_thr(line_thr),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_op(dn_op), .dn_line(dn_line),
    .dn_size(dn_size), .dn_rsp_valid(dn_rsp_valid), .cpl_valid(cpl_valid),
    .cpl_cnt(cpl_cnt), .cpl_ords(cpl_ords)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // accepted request: expects ready and the next order number
  task automatic send(input logic [2:0] k, input int line, input int sz, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_line = LW'(line); req_size = SW'(sz);
    #1;
    check({tag, " R1 ready"}, int'(req_ready), 1);
    check({tag, " R1 ord"}, int'(req_ord), ord_exp % 64);
    @(posedge clk);
    #1 req_valid = 1'b0;
    ord_exp++;
  endtask

  // offered but withdrawn before the edge
  task automatic probe(input logic [2:0] k, input int line, input int exp_rdy, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_line = LW'(line); req_size = SW'(1);
    #1 check(tag, int'(req_ready), exp_rdy);
    #1 req_valid = 1'b0;
  endtask

  // take one downstream access and answer it
  task automatic serve(input int op, input int line, input int sz, input int cnt,
                       input int first, input string tag);
    @(negedge clk);
    #1;
    check({tag, " dn_valid"}, int'(dn_valid), 1);
    check({tag, " R8 op"}, int'(dn_op), op);
    check({tag, " line"}, int'(dn_line), line);
    check({tag, " R8 size"}, int'(dn_size), sz);
    dn_ready = 1'b1;
    @(posedge clk);
    #1 dn_ready = 1'b0;
    check({tag, " R12 busy"}, int'(dn_valid), 0);
    @(negedge clk);
    dn_rsp_valid = 1'b1;
    #1;
    check({tag, " R12 cpl_valid"}, int'(cpl_valid), 1);
    check({tag, " R2 cpl_cnt"}, int'(cpl_cnt), cnt);
    for (int k = 0; k < cnt; k++) begin
      check({tag, " R3 cpl_ord"}, int'(cpl_ords[k*OW +: OW]), (first + k) % 64);
    end
    @(posedge clk);
    #1 dn_rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    check("R9 reset mq_full", int'(mq_full), 0);
    check("R9 reset wq_full", int'(wq_full), 0);
    check("R12 reset dn_valid", int'(dn_valid), 0);
    check("R12 reset cpl_valid", int'(cpl_valid), 0);
    check("R1 reset ord", int'(req_ord), 0);
    check("R10 reset line_thr", int'(line_thr), 0);
  endtask

  task automatic t_join;
    send(3'd0, 'h10, 0, "join a");
    send(3'd1, 'h10, 0, "join b");
    send(3'd0, 'h10, 0, "join c");
    serve(1, 'h10, 64, 3, 0, "R2 joined line");
  endtask

  task automatic t_uncached;
    send(3'd2, 'h20, 8, "unc a");
    send(3'd2, 'h20, 4, "unc b");
    serve(0, 'h20, 8, 1, 3, "R4 R5 first");
    serve(0, 'h20, 4, 1, 4, "R4 R5 second");
  endtask

  task automatic t_prefer;
    send(3'd3, 'h30, 16, "pref w");
    send(3'd0, 'h40, 0, "pref r");
    serve(0, 'h40, 64, 1, 6, "R6 read first");
    serve(2, 'h30, 16, 1, 5, "R6 write after");
  endtask

  task automatic t_overlap;
    send(3'd3, 'h50, 4, "ovl w");
    send(3'd0, 'h50, 0, "ovl r");
    serve(2, 'h50, 4, 1, 7, "R7 older write");
    serve(0, 'h50, 64, 1, 8, "R7 newer read");
  endtask

  task automatic t_wq_full;
    for (int i = 0; i < 4; i++) send(3'd4, 'h60 + i, 0, "wb fill");
    send(3'd2, 'h70, 2, "wf read");
    @(negedge clk); #1 check("R9 wq_full", int'(wq_full), 1);
    probe(3'd3, 'h99, 0, "R9 wq refuse");
    serve(2, 'h60, 64, 1, 9, "R6 full write first");
    serve(0, 'h70, 2, 1, 13, "R6 read resumes");
    for (int i = 1; i < 4; i++) serve(2, 'h60 + i, 64, 1, 9 + i, "R11 wb order");
  endtask

  task automatic t_thresh;
    for (int i = 0; i < 4; i++) send(3'd0, 'h80, 0, "thr fill");
    @(negedge clk);
    req_kind = 3'd0; req_line = LW'('h80);
    #1 check("R10 line_thr set", int'(line_thr), 1);
    probe(3'd1, 'h80, 0, "R10 refuse same line");
    probe(3'd0, 'h81, 1, "R10 other line ok");
    @(negedge clk);
    req_line = LW'('h81);
    #1 check("R10 line_thr other", int'(line_thr), 0);
    serve(0, 'h80, 64, 4, 14, "R10 full entry");
  endtask

  task automatic t_mq_full;
    for (int i = 0; i < 4; i++) send(3'd2, 'h90 + i, i + 1, "mq fill");
    @(negedge clk); #1 check("R9 mq_full", int'(mq_full), 1);
    probe(3'd2, 'h98, 0, "R9 mq refuse");
    probe(3'd4, 'h98, 1, "R9 wq open");
    for (int i = 0; i < 4; i++) serve(0, 'h90 + i, i + 1, 1, 18 + i, "R5 mq order");
  endtask

  task automatic t_illegal;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd7; req_line = LW'('hA0); req_size = SW'(1);
    #1 check("R11 kind7 refused", int'(req_ready), 0);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    #1 check("R11 kind7 no access", int'(dn_valid), 0);
    send(3'd0, 'hA0, 0, "R11 ord kept");
    serve(0, 'hA0, 64, 1, 22, "R11 after illegal");
  endtask

  task automatic t_wrap;
    while ((ord_exp % 64) != 63) begin
      send(3'd0, 'hC0, 0, "wrap step");
      serve(0, 'hC0, 64, 1, ord_exp - 1, "wrap serve");
    end
    send(3'd3, 'hB0, 8, "wrap w");
    send(3'd0, 'hB0, 0, "wrap r");
    serve(2, 'hB0, 8, 1, 63, "R7 wrap older write");
    serve(0, 'hB0, 64, 1, 0, "R7 wrap newer read");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_line = '0; req_size = '0;
    dn_ready = 1'b0; dn_rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_join;
    t_uncached;
    t_prefer;
    t_overlap;
    t_wq_full;
    t_thresh;
    t_mq_full;
    t_illegal;
    t_wrap;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule